// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test port for board-level interconnect testing. A four-wire serial interface (test clock, mode select, serial in, serial out) steers a sixteen-state controller. That controller moves bits through one of three shift paths: a four-bit instruction register, a one-bit bypass cell, or a boundary chain that sits between the core-side pin signals and the pad drivers. The active instruction decides two things: which data path lies between serial in and serial out, and whether the pads follow the core or follow the latched contents of the boundary chain.

The pads are modelled as a value and an output-enable per pin. Five operations are supported:
- external drive for continuity testing,
- live sampling with preload,
- bypass,
- clamp, which holds the preloaded pin values on a one-cell path,
- float, which releases every pad.

An active-low asynchronous test reset clears all test logic. A separate test-enable input also holds the test logic in reset while it is low. In that state the pads stay under core control and the port stays out of the way of other test modes.

The boundary chain has three cells per pin, with pin i using chain positions 3i, 3i+1 and 3i+2:
- position 3i captures the pad input,
- position 3i+1 captures the core output value and later supplies the driven value,
- position 3i+2 captures the core output enable and later supplies the driven enable.

Position 0 is nearest the serial output, and bits are shifted in and out least significant first.

Top module: `bscan_tap`

## Requirements
- R1: With mode select held high for five rising test-clock edges, the controller reaches its reset state from any state. In the reset state the effective instruction is bypass, so pad_out equals core_out and pad_oe equals core_oe.
- R2: While test_en is low, all test logic is held in reset. The pads follow the core, tdo_oe is 0, and clocked mode-select traffic has no effect. When test_en is raised again, the instruction is bypass.
- R3: The instruction register is 4 bits wide. It captures 4'b0001 when the instruction capture state is entered, and that value is shifted out least significant bit first.
- R4: Code 4'b1111 selects the bypass cell. Its first shifted-out bit is 0, and each later output bit equals the serial input presented one shift earlier.
- R5: Code 4'b0001 (sample) captures the three cells of every pin into chain positions 3i, 3i+1 and 3i+2, and shifts them out from position 0. The pads keep following the core while this happens.
- R6: Code 4'b0000 (external drive) drives pad_out[i] from the updated cell 3i+1 and pad_oe[i] from the updated cell 3i+2.
- R7: Code 4'b1001 (clamp) keeps driving the pads from the updated cells and selects the one-cell bypass path. A data scan in clamp does not change the pads.
- R8: Code 4'b1000 (float) forces every pad_oe to 0 and selects the one-cell bypass path.
- R9: Every instruction code other than 0000, 0001, 1000 and 1001 behaves exactly as bypass.
- R10: tdo_oe is 1 only while the controller is in the instruction shift or data shift state. tdo and tdo_oe change on the falling test-clock edge.
- R11: The updated boundary cells change only on the rising edge that leaves the data update state. Pads driven from them stay constant during shifting.
- R12: Driving trst_n low resets the test logic at once, without a clock edge, and the pads return to core control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| test_en | input | 1 | Test logic enable; low holds all test logic in reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Serial out driver enable |
| core_out | input | NPIN | Core-side output values |
| core_oe | input | NPIN | Core-side output enables |
| pad_in | input | NPIN | Values seen at the pins |
| pad_out | output | NPIN | Values driven to the pins |
| pad_oe | output | NPIN | Pin driver enables |

## Verification
A corrupted controller state shows up at the ports within one test-clock period. It appears as tdo_oe asserted outside a shift state, as a scan of the wrong length, or as a missing bypass zero at the head of a data scan. A wrong instruction decode shows immediately after the update edge, because the pads switch between core and boundary sources. A corrupted boundary or update cell shows as a wrong captured bit at a known shift position, or as a pad that moves during shifting. The bench sweeps every pad-input value through sample and every instruction code through the decoder, so a single bad cell mapping or decode entry is observed within one scan.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    MD_FUNC, MD_EXT, MD_SAMPLE, MD_CLAMP, MD_FLOAT
  } pad_mode_e;

  localparam logic [IR_W-1:0] OP_EXT     = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_FLOAT   = 4'b1000;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b1001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAP_VAL = 4'b0001;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge rst) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // R1: the reset state is held while mode select stays high
  p_reset_hold_r1: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET && tms) |=> state == ST_RESET);

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       so,
  output pad_mode_e  mode,
  output logic       sel_chain
);

  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] op_q;
  logic [IR_W-1:0] op_eff;

  always_ff @(posedge tck or posedge rst) begin
    if (rst) begin
      sr_q <= IR_CAP_VAL;
      op_q <= OP_BYPASS;
    end else begin
      unique case (state)
        ST_RESET:  op_q <= OP_BYPASS;
        ST_CAP_IR: sr_q <= IR_CAP_VAL;
        ST_SH_IR:  sr_q <= {tdi, sr_q[IR_W-1:1]};
        ST_UPD_IR: op_q <= sr_q;
        default:   ;
      endcase
    end
  end

  // the reset state overrides the latched code at once
  assign op_eff = (state == ST_RESET) ? OP_BYPASS : op_q;
  assign so     = sr_q[0];

  always_comb begin
    unique case (op_eff)
      OP_EXT:    mode = MD_EXT;
      OP_SAMPLE: mode = MD_SAMPLE;
      OP_CLAMP:  mode = MD_CLAMP;
      OP_FLOAT:  mode = MD_FLOAT;
      default:   mode = MD_FUNC;
    endcase
  end

  assign sel_chain = (mode == MD_EXT) || (mode == MD_SAMPLE);

  // R3: the fixed pattern is loaded on capture
  p_ir_capture_r3: assert property (@(posedge tck) disable iff (rst)
    state == ST_CAP_IR |=> sr_q == IR_CAP_VAL);

  // R1: passing through the reset state leaves bypass latched
  p_reset_bypass_r1: assert property (@(posedge tck) disable iff (rst)
    state == ST_RESET |=> op_q == OP_BYPASS);

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            sel,
  input  logic            tdi,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic            so,
  output logic [NPIN-1:0] upd_out,
  output logic [NPIN-1:0] upd_oe
);

  localparam int CPP = 3;
  localparam int LEN = CPP * NPIN;

  logic [LEN-1:0]    sr_q;
  logic [LEN-1:0]    cap;
  logic [2*NPIN-1:0] upd_q;
  logic [2*NPIN-1:0] upd_nxt;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign cap[CPP*i]     = pad_in[i];
    assign cap[CPP*i+1]   = core_out[i];
    assign cap[CPP*i+2]   = core_oe[i];
    assign upd_nxt[2*i]   = sr_q[CPP*i+1];
    assign upd_nxt[2*i+1] = sr_q[CPP*i+2];
    assign upd_out[i]     = upd_q[2*i];
    assign upd_oe[i]      = upd_q[2*i+1];
  end

  always_ff @(posedge tck or posedge rst) begin
    if (rst) begin
      sr_q  <= '0;
      upd_q <= '0;
    end else if (sel) begin
      unique case (state)
        ST_CAP_DR: sr_q  <= cap;
        ST_SH_DR:  sr_q  <= {tdi, sr_q[LEN-1:1]};
        ST_UPD_DR: upd_q <= upd_nxt;
        default:   ;
      endcase
    end
  end

  assign so = sr_q[0];

  // R11: latched cells move only on the edge leaving data update
  p_upd_hold_r11: assert property (@(posedge tck) disable iff (rst)
    state != ST_UPD_DR |=> $stable(upd_q));

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            test_en,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);

  logic            rst;
  tap_state_e      state;
  pad_mode_e       mode;
  logic            sel_chain;
  logic            ir_so;
  logic            ch_so;
  logic            byp_q;
  logic            dr_so;
  logic [NPIN-1:0] upd_out;
  logic [NPIN-1:0] upd_oe;
  logic            drive_cells;

  assign rst = !trst_n || !test_en;

  bscan_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  bscan_ir u_ir (
    .tck       (tck),
    .rst       (rst),
    .state     (state),
    .tdi       (tdi),
    .so        (ir_so),
    .mode      (mode),
    .sel_chain (sel_chain)
  );

  bscan_chain #(.NPIN(NPIN)) u_chain (
    .tck      (tck),
    .rst      (rst),
    .state    (state),
    .sel      (sel_chain),
    .tdi      (tdi),
    .pad_in   (pad_in),
    .core_out (core_out),
    .core_oe  (core_oe),
    .so       (ch_so),
    .upd_out  (upd_out),
    .upd_oe   (upd_oe)
  );

  // single bypass cell, also the path for clamp and float
  always_ff @(posedge tck or posedge rst) begin
    if (rst) byp_q <= 1'b0;
    else if (!sel_chain) begin
      if (state == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state == ST_SH_DR) byp_q <= tdi;
    end
  end

  assign dr_so = sel_chain ? ch_so : byp_q;

  // serial output is retimed on the falling edge
  always_ff @(negedge tck or posedge rst) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  assign drive_cells = (mode == MD_EXT) || (mode == MD_CLAMP);

  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    assign pad_out[i] = drive_cells ? upd_out[i] : core_out[i];
    assign pad_oe[i]  = (mode == MD_FLOAT) ? 1'b0 :
                        drive_cells ? upd_oe[i] : core_oe[i];
  end

  // R4: bypass capture loads zero
  p_bypass_cap_r4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && !sel_chain) |=> byp_q == 1'b0);

  // R4: bypass shift delays serial input by one edge
  p_bypass_shift_r4: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SH_DR && !sel_chain) |=> byp_q == $past(tdi));

endmodule

// File: tb/bscan_tap_tb.sv
module bscan_tap_tb_top;

  localparam int NPIN = 4;
  localparam int LEN  = 3 * NPIN;
  localparam int TCK_PERIOD = 20;
  localparam int HALF = TCK_PERIOD / 2;

  logic tck = 1'b0, trst_n = 1'b1, test_en = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [NPIN-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  bscan_tap #(.NPIN(NPIN)) dut_i (
    .tck(tck), .trst_n(trst_n), .test_en(test_en), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .core_out(core_out), .core_oe(core_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
    #HALF tck = 1'b1;
    #HALF tck = 1'b0;
    #1;
  endtask

  task automatic go_idle();
    logic o, oe;
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
  endtask

  task automatic ir_load(input logic [3:0] code, input bit chk, output logic [3:0] cap);
    logic o, oe;
    step(1'b1, 1'b0, o, oe);
    if (chk) check("R10 idle tdo_oe", oe, 1'b0);
    step(1'b1, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
    for (int k = 0; k < 4; k++) begin
      step(k == 3, code[k], o, oe);
      cap[k] = o;
      if (chk && k == 0) check("R10 shift-IR tdo_oe", oe, 1'b1);
    end
    step(1'b1, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
  endtask

  task automatic dr_scan(input int len, input logic [63:0] din, input bit stable,
                         output logic [63:0] dout);
    logic o, oe;
    logic [NPIN-1:0] po, pe;
    bit moved = 0;
    dout = '0;
    step(1'b1, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
    step(1'b0, 1'b0, o, oe);
    po = pad_out; pe = pad_oe;
    for (int k = 0; k < len; k++) begin
      step(k == len - 1, din[k], o, oe);
      dout[k] = o;
      if (pad_out !== po || pad_oe !== pe) moved = 1;
    end
    step(1'b1, 1'b0, o, oe);
    if (pad_out !== po || pad_oe !== pe) moved = 1;
    if (stable) check("R11 pads steady while shifting", moved, 1'b0);
    step(1'b0, 1'b0, o, oe);
  endtask

  function automatic logic [NPIN-1:0] cell_out(input logic [LEN-1:0] p);
    for (int i = 0; i < NPIN; i++) cell_out[i] = p[3*i+1];
  endfunction

  function automatic logic [NPIN-1:0] cell_oe(input logic [LEN-1:0] p);
    for (int i = 0; i < NPIN; i++) cell_oe[i] = p[3*i+2];
  endfunction

  function automatic logic [LEN-1:0] cap_exp(input logic [NPIN-1:0] pi,
      input logic [NPIN-1:0] co, input logic [NPIN-1:0] ce);
    for (int i = 0; i < NPIN; i++) begin
      cap_exp[3*i]   = pi[i];
      cap_exp[3*i+1] = co[i];
      cap_exp[3*i+2] = ce[i];
    end
  endfunction

  task automatic check_func(input string req);
    check(req, {pad_out, pad_oe}, {core_out, core_oe});
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] dout;
    logic [LEN-1:0] pat;
    logic o, oe;

    #1 trst_n = 1'b0;
    #(TCK_PERIOD) trst_n = 1'b1;
    core_out = 4'hA; core_oe = 4'h6;
    #1;
    check("R12 reset tdo_oe", tdo_oe, 1'b0);
    check_func("R1 reset pads functional");
    go_idle();

    // R3: instruction capture pattern
    ir_load(4'b0001, 1, cap);
    check("R3 IR capture", cap, 4'b0001);

    // R5: sample sweep over every pad input value
    pat = '0;
    for (int v = 0; v < 16; v++) begin
      pad_in = v[3:0]; core_out = ~v[3:0]; core_oe = v[3:0] ^ 4'h5;
      pat = 12'hA5C ^ LEN'(v * 37);
      dr_scan(LEN, 64'(pat), 0, dout);
      check("R5 sample capture", dout[LEN-1:0], cap_exp(pad_in, core_out, core_oe));
      check_func("R5 pads functional in sample");
    end

    // R6: external drive from preloaded cells
    ir_load(4'b0000, 1, cap);
    check("R3 IR capture again", cap, 4'b0001);
    check("R6 ext drive", {pad_out, pad_oe}, {cell_out(pat), cell_oe(pat)});
    dr_scan(LEN, 64'(12'h3C6), 1, dout);
    check("R6 ext capture", dout[LEN-1:0], cap_exp(pad_in, core_out, core_oe));
    pat = 12'h3C6;
    check("R11 R6 after update", {pad_out, pad_oe}, {cell_out(pat), cell_oe(pat)});

    // R7: clamp holds the cells, one-cell path
    ir_load(4'b1001, 1, cap);
    check("R7 clamp pads", {pad_out, pad_oe}, {cell_out(pat), cell_oe(pat)});
    dr_scan(4, 64'b1011, 0, dout);
    check("R7 clamp bypass path", dout[3:0], 4'b0110);
    check("R7 clamp pads after scan", {pad_out, pad_oe}, {cell_out(pat), cell_oe(pat)});

    // R8: float
    ir_load(4'b1000, 1, cap);
    check("R8 float oe", pad_oe, 4'b0000);
    dr_scan(3, 64'b110, 0, dout);
    check("R8 float bypass path", dout[2:0], 3'b100);
    check("R8 float oe after scan", pad_oe, 4'b0000);

    // R9 and R4: every other code acts as bypass
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c == 1 || c == 8 || c == 9) continue;
      ir_load(c[3:0], 0, cap);
      dr_scan(3, 64'b101, 0, dout);
      check(c == 15 ? "R4 bypass path" : "R9 unused code path", dout[2:0], 3'b010);
      check_func("R9 unused code pads");
    end

    // R1: five ones from external drive
    ir_load(4'b0000, 0, cap);
    check("R1 ext active before reset walk", pad_oe, cell_oe(pat));
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, o, oe);
    check_func("R1 five ones give functional pads");
    step(1'b0, 1'b0, o, oe);

    // R2: test enable low holds reset
    ir_load(4'b0000, 0, cap);
    test_en = 1'b0;
    #1;
    check_func("R2 enable low pads");
    check("R2 enable low tdo_oe", tdo_oe, 1'b0);
    ir_load(4'b1000, 0, cap);
    check_func("R2 clocks ignored while disabled");
    test_en = 1'b1;
    #1;
    go_idle();
    dr_scan(3, 64'b101, 0, dout);
    check("R2 bypass after enable", dout[2:0], 3'b010);
    check_func("R2 pads after enable");

    // R12: asynchronous test reset
    ir_load(4'b1000, 0, cap);
    check("R12 float before reset", pad_oe, 4'b0000);
    trst_n = 1'b0;
    #2;
    check_func("R12 async reset pads");
    trst_n = 1'b1;
    #1;
    go_idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule